// File: doc/BRIEF.md
# Cluster Power-Up Sequencer

This block is a hardware state machine that brings a secondary processor cluster from fully off to running. It starts on a single-cycle start request that carries a cluster index. It then drives that cluster's control outputs through a fixed series of steps:

- release of the cluster reset;
- removal of isolation;
- PLL power-up with a held output isolation;
- PLL configuration load;
- release of the clock-source soft reset;
- divider load and a clock-change trigger;
- functional clock enables;
- the interconnect power-down control;
- three soft-reset release groups.

Each microsecond wait is measured by a down-counter of `CLK_MHZ` cycles per microsecond.

Cluster 0 is the boot cluster and comes out of reset already running. The other clusters come out of reset off. The block keeps a per-cluster "on" status. It ignores a request for a cluster that is already on, a request for an index that does not name a secondary cluster, and any request that arrives while a sequence is in flight.

All control outputs are vectors with one bit per cluster; per-core isolation uses `CORES` bits per cluster. Every output holds its level between steps, except the configuration-load, divider-load and trigger strobes, which pulse for one cycle.

Top module: `cluster_pwrup_seq`

## Requirements
In the timings below, M is `CLK_MHZ`, and "offset k" means k clock edges after the edge that accepts a request. At that accepting edge, `busy_o` rises.

- R1: After reset, cluster 0 reads fully powered:
  - reset released, PLL LDO and power on, clock source released, clocks enabled, interconnect bit set;
  - bus, peripheral and L2 resets released;
  - all isolation cleared, except cluster DFT and memory isolation, which read 1.

  All other clusters read the opposite:
  - reset held, cluster I/O isolation 1, DFT and memory isolation 0;
  - every core I/O and memory isolation bit 1;
  - all PLL, clock, interconnect and active-low reset outputs 0.

  All strobes are 0, `busy_o` is 0 and `done_o` is 0.
- R2: A request naming a cluster whose status is on is ignored: `busy_o` stays 0 and no output changes. A cluster's status turns on when its sequence ends.
- R3: A request whose index is 0 or is at least `NUM_CL` is rejected, with no output change.
- R4: The isolation and reset-release steps run one cycle apart:
  - offset 1: the cluster reset release goes to 1;
  - offset 2: cluster I/O isolation clears, while DFT and memory isolation go to 1;
  - offset 3: both core I/O and memory isolation bits of that cluster clear.
- R5: At offset 4, PLL LDO, PLL power and PLL output isolation go to 1 together. At offset 5+2M, output isolation drops while LDO and power stay 1, so output isolation is held for at least 2M cycles.
- R6: The configuration-load strobe pulses at offset 6+2M. The active-low clock-source reset releases at offset 7+3M, after a wait of at least M cycles. A further wait of at least M cycles follows it.
- R7: The divider-load strobe pulses at offset 8+4M. The clock-change trigger pulses at 9+4M. The functional clock enable goes to 1 at 10+4M.
- R8: The interconnect power-down control bit for the cluster goes to 1 at offset 11+4M. This is after the clocks are enabled and before any reset group is released.
- R9: The reset groups release in a fixed order: the bus-clock group at offset 12+4M, the peripheral group at 13+4M, and the L2 group at 14+4M. Core resets are not driven.
- R10: At the L2 release edge, `done_o` pulses high for exactly one cycle and `busy_o` falls. `busy_o` is high from the accepting edge until then.
- R11: A request made while `busy_o` is high is ignored: the named cluster's outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Power-up request strobe |
| cluster_i | input | CID_W | Index of the cluster to power up |
| busy_o | output | 1 | Sequence in flight |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| rst_rel_o | output | NUM_CL | Cluster reset release (1 = released) |
| cl_io_iso_o | output | NUM_CL | Cluster I/O isolation |
| cl_dft_iso_o | output | NUM_CL | Cluster DFT isolation |
| cl_mem_iso_o | output | NUM_CL | Cluster memory isolation |
| core_io_iso_o | output | NUM_CL*CORES | Per-core I/O isolation |
| core_mem_iso_o | output | NUM_CL*CORES | Per-core memory isolation |
| pll_ldo_o | output | NUM_CL | PLL regulator enable |
| pll_pwr_o | output | NUM_CL | PLL power enable |
| pll_oiso_o | output | NUM_CL | PLL output isolation |
| pll_cfg_ld_o | output | NUM_CL | PLL configuration load strobe |
| clksrc_rst_n_o | output | NUM_CL | Crystal and PLL soft reset, active low |
| div_ld_o | output | NUM_CL | Divider load strobe |
| div_trig_o | output | NUM_CL | Clock-change trigger strobe |
| clk_en_o | output | NUM_CL | Functional clock enables |
| xbar_pd_o | output | NUM_CL | Interconnect power-down control bit |
| bus_rst_n_o | output | NUM_CL | Bus-clock reset group, active low |
| periph_rst_n_o | output | NUM_CL | Peripheral/thermal reset group, active low |
| l2_rst_n_o | output | NUM_CL | L2 reset group, active low |

## Verification
The main sequence is tried with several request patterns:

- a clean single request;
- a request that is held high across the end of a sequence and into idle;
- a second request issued in the middle of a running sequence;
- sequences run for every secondary cluster in a non-monotonic order.

The clean request fixes the step offsets. The held request separates a design that re-arms on an already-on cluster from one that does not. The mid-sequence request exposes a design that retargets or corrupts the in-flight cluster. Requests for index 0, for indices at or above the cluster count, and for a finished cluster tell rejection apart from acceptance, because every output is compared against the model on every cycle.

// File: rtl/cps_pkg.sv
// Package: shared state encoding for the cluster power-up sequencer.
// Assumes: one sequence runs at a time; each state lasts one cycle except the timed waits.
package cps_pkg;
    typedef enum logic [4:0] {
        ST_IDLE,
        ST_RST,
        ST_CLISO,
        ST_COREISO,
        ST_PLLON,
        ST_WPLL,
        ST_PLLISO,
        ST_CFG,
        ST_W1,
        ST_CLKSRC,
        ST_W2,
        ST_DIV,
        ST_TRIG,
        ST_CLKEN,
        ST_XBAR,
        ST_BUS,
        ST_PERIPH,
        ST_L2
    } seq_st_e;
endpackage

// File: rtl/cps_us_timer.sv
// Module: down-counter used for the microsecond waits.
// Assumes: a load takes priority over counting; the counter sticks at zero.
module cps_us_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a fresh count, or decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (ld_i)        cnt_q <= val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cps_seq_fsm.sv
// Module: step controller. It accepts requests, keeps the per-cluster on status,
// walks the step states and loads the wait timer.
// Assumes: cluster 0 is on at reset; valid indices are 1 .. NUM_CL-1.
module cps_seq_fsm
    import cps_pkg::*;
#(
    parameter int NUM_CL  = 4,
    parameter int CID_W   = 3,
    parameter int CLK_MHZ = 4,
    parameter int TMR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CID_W-1:0]  cluster_i,
    input  logic              tmr_zero_i,
    output seq_st_e           st_o,
    output logic [NUM_CL-1:0] sel_o,
    output logic              tmr_ld_o,
    output logic [TMR_W-1:0]  tmr_val_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CID_W-1:0]  LAST_ID = CID_W'(NUM_CL - 1);
    localparam logic [NUM_CL-1:0] ON0     = NUM_CL'(1);
    localparam logic [TMR_W-1:0]  T_PLL   = TMR_W'(2 * CLK_MHZ - 1);
    localparam logic [TMR_W-1:0]  T_US    = TMR_W'(CLK_MHZ - 1);

    seq_st_e           st_q, st_d;
    logic [NUM_CL-1:0] on_q, hit_sel;
    logic              busy_q, done_q, already_on, accept;

    // Decode the requested index into a one-hot select and look up its status.
    always_comb begin
        hit_sel = '0;
        for (int i = 0; i < NUM_CL; i++) hit_sel[i] = (cluster_i == CID_W'(i));
        already_on = |(hit_sel & on_q);
    end

    assign accept = (st_q == ST_IDLE) && start_i && (cluster_i != '0)
                    && (cluster_i <= LAST_ID) && !already_on;

    // Next-state selection for the step walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (accept) st_d = ST_RST;
            ST_RST:     st_d = ST_CLISO;
            ST_CLISO:   st_d = ST_COREISO;
            ST_COREISO: st_d = ST_PLLON;
            ST_PLLON:   st_d = ST_WPLL;
            ST_WPLL:    if (tmr_zero_i) st_d = ST_PLLISO;
            ST_PLLISO:  st_d = ST_CFG;
            ST_CFG:     st_d = ST_W1;
            ST_W1:      if (tmr_zero_i) st_d = ST_CLKSRC;
            ST_CLKSRC:  st_d = ST_W2;
            ST_W2:      if (tmr_zero_i) st_d = ST_DIV;
            ST_DIV:     st_d = ST_TRIG;
            ST_TRIG:    st_d = ST_CLKEN;
            ST_CLKEN:   st_d = ST_XBAR;
            ST_XBAR:    st_d = ST_BUS;
            ST_BUS:     st_d = ST_PERIPH;
            ST_PERIPH:  st_d = ST_L2;
            ST_L2:      st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Timer loads: a doubled microsecond for the PLL isolation hold, one microsecond elsewhere.
    always_comb begin
        tmr_ld_o  = 1'b0;
        tmr_val_o = T_US;
        if (st_q == ST_PLLON) begin
            tmr_ld_o  = 1'b1;
            tmr_val_o = T_PLL;
        end else if (st_q == ST_CFG || st_q == ST_CLKSRC) begin
            tmr_ld_o = 1'b1;
        end
    end

    // State, target cluster, status and busy/done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sel_o  <= '0;
            on_q   <= ON0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_L2);
            if (accept) begin
                sel_o  <= hit_sel;
                busy_q <= 1'b1;
            end
            if (st_q == ST_L2) begin
                busy_q <= 1'b0;
                on_q   <= on_q | sel_o;
            end
        end
    end

    assign st_o   = st_q;
    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/cps_cluster_ctl.sv
// Module: per-cluster control registers. It applies the action of the current step
// to the selected cluster and holds every level between steps.
// Assumes: at most one select bit is high; strobes last one cycle.
module cps_cluster_ctl
    import cps_pkg::*;
#(
    parameter int NUM_CL = 4,
    parameter int CORES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  seq_st_e                 st_i,
    input  logic [NUM_CL-1:0]       sel_i,
    output logic [NUM_CL-1:0]       rst_rel_o,
    output logic [NUM_CL-1:0]       cl_io_iso_o,
    output logic [NUM_CL-1:0]       cl_dft_iso_o,
    output logic [NUM_CL-1:0]       cl_mem_iso_o,
    output logic [NUM_CL*CORES-1:0] core_io_iso_o,
    output logic [NUM_CL*CORES-1:0] core_mem_iso_o,
    output logic [NUM_CL-1:0]       pll_ldo_o,
    output logic [NUM_CL-1:0]       pll_pwr_o,
    output logic [NUM_CL-1:0]       pll_oiso_o,
    output logic [NUM_CL-1:0]       pll_cfg_ld_o,
    output logic [NUM_CL-1:0]       clksrc_rst_n_o,
    output logic [NUM_CL-1:0]       div_ld_o,
    output logic [NUM_CL-1:0]       div_trig_o,
    output logic [NUM_CL-1:0]       clk_en_o,
    output logic [NUM_CL-1:0]       xbar_pd_o,
    output logic [NUM_CL-1:0]       bus_rst_n_o,
    output logic [NUM_CL-1:0]       periph_rst_n_o,
    output logic [NUM_CL-1:0]       l2_rst_n_o
);
    localparam int                  CW      = NUM_CL * CORES;
    localparam logic [NUM_CL-1:0]   ON0     = NUM_CL'(1);
    localparam logic [CW-1:0]       CORE_ON = CW'((1 << CORES) - 1);

    // Reset to "cluster 0 running, others off"; otherwise apply the step to the selected cluster.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_rel_o      <= ON0;
            cl_io_iso_o    <= ~ON0;
            cl_dft_iso_o   <= ON0;
            cl_mem_iso_o   <= ON0;
            core_io_iso_o  <= ~CORE_ON;
            core_mem_iso_o <= ~CORE_ON;
            pll_ldo_o      <= ON0;
            pll_pwr_o      <= ON0;
            pll_oiso_o     <= '0;
            pll_cfg_ld_o   <= '0;
            clksrc_rst_n_o <= ON0;
            div_ld_o       <= '0;
            div_trig_o     <= '0;
            clk_en_o       <= ON0;
            xbar_pd_o      <= ON0;
            bus_rst_n_o    <= ON0;
            periph_rst_n_o <= ON0;
            l2_rst_n_o     <= ON0;
        end else begin
            pll_cfg_ld_o <= '0;
            div_ld_o     <= '0;
            div_trig_o   <= '0;
            for (int g = 0; g < NUM_CL; g++) begin
                if (sel_i[g]) begin
                    case (st_i)
                        ST_RST: rst_rel_o[g] <= 1'b1;
                        ST_CLISO: begin
                            cl_io_iso_o[g]  <= 1'b0;
                            cl_dft_iso_o[g] <= 1'b1;
                            cl_mem_iso_o[g] <= 1'b1;
                        end
                        ST_COREISO: begin
                            core_io_iso_o[g*CORES +: CORES]  <= '0;
                            core_mem_iso_o[g*CORES +: CORES] <= '0;
                        end
                        ST_PLLON: begin
                            pll_ldo_o[g]  <= 1'b1;
                            pll_pwr_o[g]  <= 1'b1;
                            pll_oiso_o[g] <= 1'b1;
                        end
                        ST_PLLISO: pll_oiso_o[g]     <= 1'b0;
                        ST_CFG:    pll_cfg_ld_o[g]   <= 1'b1;
                        ST_CLKSRC: clksrc_rst_n_o[g] <= 1'b1;
                        ST_DIV:    div_ld_o[g]       <= 1'b1;
                        ST_TRIG:   div_trig_o[g]     <= 1'b1;
                        ST_CLKEN:  clk_en_o[g]       <= 1'b1;
                        ST_XBAR:   xbar_pd_o[g]      <= 1'b1;
                        ST_BUS:    bus_rst_n_o[g]    <= 1'b1;
                        ST_PERIPH: periph_rst_n_o[g] <= 1'b1;
                        ST_L2:     l2_rst_n_o[g]     <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/cluster_pwrup_seq.sv
// Module: top of the cluster power-up sequencer. It joins the step controller,
// the microsecond timer and the per-cluster control registers.
// Assumes: CLK_MHZ is the clock frequency in MHz; cluster 0 is the boot cluster.
module cluster_pwrup_seq
    import cps_pkg::*;
#(
    parameter int NUM_CL  = 4,
    parameter int CORES   = 2,
    parameter int CID_W   = 3,
    parameter int CLK_MHZ = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CID_W-1:0]        cluster_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [NUM_CL-1:0]       rst_rel_o,
    output logic [NUM_CL-1:0]       cl_io_iso_o,
    output logic [NUM_CL-1:0]       cl_dft_iso_o,
    output logic [NUM_CL-1:0]       cl_mem_iso_o,
    output logic [NUM_CL*CORES-1:0] core_io_iso_o,
    output logic [NUM_CL*CORES-1:0] core_mem_iso_o,
    output logic [NUM_CL-1:0]       pll_ldo_o,
    output logic [NUM_CL-1:0]       pll_pwr_o,
    output logic [NUM_CL-1:0]       pll_oiso_o,
    output logic [NUM_CL-1:0]       pll_cfg_ld_o,
    output logic [NUM_CL-1:0]       clksrc_rst_n_o,
    output logic [NUM_CL-1:0]       div_ld_o,
    output logic [NUM_CL-1:0]       div_trig_o,
    output logic [NUM_CL-1:0]       clk_en_o,
    output logic [NUM_CL-1:0]       xbar_pd_o,
    output logic [NUM_CL-1:0]       bus_rst_n_o,
    output logic [NUM_CL-1:0]       periph_rst_n_o,
    output logic [NUM_CL-1:0]       l2_rst_n_o
);
    localparam int TMR_W = $clog2(2 * CLK_MHZ + 1);

    seq_st_e           st;
    logic [NUM_CL-1:0] sel;
    logic              tmr_ld, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;

    cps_seq_fsm #(.NUM_CL(NUM_CL), .CID_W(CID_W), .CLK_MHZ(CLK_MHZ), .TMR_W(TMR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cluster_i(cluster_i),
        .tmr_zero_i(tmr_zero), .st_o(st), .sel_o(sel), .tmr_ld_o(tmr_ld),
        .tmr_val_o(tmr_val), .busy_o(busy_o), .done_o(done_o)
    );

    cps_us_timer #(.W(TMR_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .ld_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    cps_cluster_ctl #(.NUM_CL(NUM_CL), .CORES(CORES)) ctl_i (
        .clk(clk), .rst_n(rst_n), .st_i(st), .sel_i(sel),
        .rst_rel_o(rst_rel_o), .cl_io_iso_o(cl_io_iso_o), .cl_dft_iso_o(cl_dft_iso_o),
        .cl_mem_iso_o(cl_mem_iso_o), .core_io_iso_o(core_io_iso_o),
        .core_mem_iso_o(core_mem_iso_o), .pll_ldo_o(pll_ldo_o), .pll_pwr_o(pll_pwr_o),
        .pll_oiso_o(pll_oiso_o), .pll_cfg_ld_o(pll_cfg_ld_o),
        .clksrc_rst_n_o(clksrc_rst_n_o), .div_ld_o(div_ld_o), .div_trig_o(div_trig_o),
        .clk_en_o(clk_en_o), .xbar_pd_o(xbar_pd_o), .bus_rst_n_o(bus_rst_n_o),
        .periph_rst_n_o(periph_rst_n_o), .l2_rst_n_o(l2_rst_n_o)
    );
endmodule

// File: rtl/cps_chk.sv
// Module: property checker for the cluster power-up sequencer, bound to the top.
// Assumes: it only observes ports; the PLL hold window is measured with its own counter.
module cps_chk #(
    parameter int NUM_CL  = 4,
    parameter int CLK_MHZ = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [NUM_CL-1:0] rst_rel_o,
    input logic [NUM_CL-1:0] cl_io_iso_o,
    input logic [NUM_CL-1:0] pll_pwr_o,
    input logic [NUM_CL-1:0] pll_oiso_o,
    input logic [NUM_CL-1:0] clksrc_rst_n_o,
    input logic [NUM_CL-1:0] div_ld_o,
    input logic [NUM_CL-1:0] div_trig_o,
    input logic [NUM_CL-1:0] clk_en_o,
    input logic [NUM_CL-1:0] xbar_pd_o,
    input logic [NUM_CL-1:0] bus_rst_n_o,
    input logic [NUM_CL-1:0] periph_rst_n_o,
    input logic [NUM_CL-1:0] l2_rst_n_o
);
    localparam int HC_W = $clog2(2 * CLK_MHZ + 2) + 1;
    logic [HC_W-1:0] hold_cnt;

    // Count the cycles during which any PLL output isolation is held.
    always_ff @(posedge clk) begin
        if (!rst_n || !(|pll_oiso_o)) hold_cnt <= '0;
        else                          hold_cnt <= hold_cnt + 1'b1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R10
    AST_PLL_ISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|pll_oiso_o) |-> (hold_cnt >= HC_W'(2 * CLK_MHZ))); // R5
    AST_TRIG_AFTER_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (|div_trig_o) |-> ($past(div_ld_o) == div_trig_o)); // R7
    AST_CLKEN_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_en_o & ~$past(clk_en_o)) != '0) |-> ($past(div_trig_o) == (clk_en_o & ~$past(clk_en_o)))); // R7
    AST_ISO_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (~cl_io_iso_o & ~rst_rel_o) == '0); // R4
    AST_CLKSRC_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (clksrc_rst_n_o & ~pll_pwr_o) == '0); // R6
    AST_XBAR_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rst_n_o & ~xbar_pd_o) == '0) && ((xbar_pd_o & ~clk_en_o) == '0)); // R8
    AST_RESET_GROUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((l2_rst_n_o & ~periph_rst_n_o) == '0) && ((periph_rst_n_o & ~bus_rst_n_o) == '0)); // R9
endmodule

bind cluster_pwrup_seq cps_chk #(.NUM_CL(NUM_CL), .CLK_MHZ(CLK_MHZ)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .rst_rel_o(rst_rel_o), .cl_io_iso_o(cl_io_iso_o), .pll_pwr_o(pll_pwr_o),
    .pll_oiso_o(pll_oiso_o), .clksrc_rst_n_o(clksrc_rst_n_o), .div_ld_o(div_ld_o),
    .div_trig_o(div_trig_o), .clk_en_o(clk_en_o), .xbar_pd_o(xbar_pd_o),
    .bus_rst_n_o(bus_rst_n_o), .periph_rst_n_o(periph_rst_n_o), .l2_rst_n_o(l2_rst_n_o)
);

// File: tb/cluster_pwrup_seq_tb_top.sv
// Bench: a behavioural timeline model, indexed by cycles since acceptance, compared on every clock.
module cluster_pwrup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int CR = 2;
    localparam int CW = 3;
    localparam int M  = 4;
    localparam int D  = 14 + 4 * M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] cluster = '0;

    logic busy, done;
    logic [NC-1:0] rst_rel, io_iso, dft_iso, mem_iso, ldo, pwr, oiso, cfg_ld, clksrc;
    logic [NC-1:0] dld, trig, clk_en, xbar, bus, periph, l2;
    logic [NC*CR-1:0] c_io, c_mem;

    cluster_pwrup_seq #(.NUM_CL(NC), .CORES(CR), .CID_W(CW), .CLK_MHZ(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cluster_i(cluster),
        .busy_o(busy), .done_o(done), .rst_rel_o(rst_rel), .cl_io_iso_o(io_iso),
        .cl_dft_iso_o(dft_iso), .cl_mem_iso_o(mem_iso), .core_io_iso_o(c_io),
        .core_mem_iso_o(c_mem), .pll_ldo_o(ldo), .pll_pwr_o(pwr), .pll_oiso_o(oiso),
        .pll_cfg_ld_o(cfg_ld), .clksrc_rst_n_o(clksrc), .div_ld_o(dld), .div_trig_o(trig),
        .clk_en_o(clk_en), .xbar_pd_o(xbar), .bus_rst_n_o(bus), .periph_rst_n_o(periph),
        .l2_rst_n_o(l2)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit armed = 0;

    // Model state
    bit m_busy, m_done;
    int t, cur;
    logic [NC-1:0] m_on, m_rel, m_io, m_dft, m_mem, m_ldo, m_pwr, m_oiso, m_cfg, m_src;
    logic [NC-1:0] m_dld, m_trig, m_en, m_xbar, m_bus, m_per, m_l2;
    logic [NC*CR-1:0] m_cio, m_cmem;

    task automatic chk(input string what, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Timeline model: events keyed by the cycle offset from the accepting edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; t = 0; cur = 0;
            m_on = 4'b0001; m_rel = 4'b0001; m_io = 4'b1110; m_dft = 4'b0001; m_mem = 4'b0001;
            m_cio = 8'b1111_1100; m_cmem = 8'b1111_1100;
            m_ldo = 4'b0001; m_pwr = 4'b0001; m_oiso = '0; m_cfg = '0; m_src = 4'b0001;
            m_dld = '0; m_trig = '0; m_en = 4'b0001; m_xbar = 4'b0001;
            m_bus = 4'b0001; m_per = 4'b0001; m_l2 = 4'b0001;
        end else begin
            m_cfg = '0; m_dld = '0; m_trig = '0; m_done = 0;
            if (m_busy) begin
                t++;
                if (t == 1) m_rel[cur] = 1;
                if (t == 2) begin m_io[cur] = 0; m_dft[cur] = 1; m_mem[cur] = 1; end
                if (t == 3) for (int k = 0; k < CR; k++) begin m_cio[cur*CR+k] = 0; m_cmem[cur*CR+k] = 0; end
                if (t == 4) begin m_ldo[cur] = 1; m_pwr[cur] = 1; m_oiso[cur] = 1; end
                if (t == 5 + 2*M) m_oiso[cur] = 0;
                if (t == 6 + 2*M) m_cfg[cur] = 1;
                if (t == 7 + 3*M) m_src[cur] = 1;
                if (t == 8 + 4*M) m_dld[cur] = 1;
                if (t == 9 + 4*M) m_trig[cur] = 1;
                if (t == 10 + 4*M) m_en[cur] = 1;
                if (t == 11 + 4*M) m_xbar[cur] = 1;
                if (t == 12 + 4*M) m_bus[cur] = 1;
                if (t == 13 + 4*M) m_per[cur] = 1;
                if (t == D) begin m_l2[cur] = 1; m_done = 1; m_busy = 0; m_on[cur] = 1; end
            end else if (start && cluster >= 1 && cluster < NC && !m_on[cluster]) begin
                m_busy = 1; t = 0; cur = int'(cluster);
            end
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk("busy", "R10", 64'(busy), 64'(m_busy));
            chk("done", "R10", 64'(done), 64'(m_done));
            chk("rst_rel", "R4", 64'(rst_rel), 64'(m_rel));
            chk("cl_iso", "R4", 64'({io_iso, dft_iso, mem_iso}), 64'({m_io, m_dft, m_mem}));
            chk("core_iso", "R4", 64'({c_io, c_mem}), 64'({m_cio, m_cmem}));
            chk("pll", "R5", 64'({ldo, pwr, oiso}), 64'({m_ldo, m_pwr, m_oiso}));
            chk("cfg_clksrc", "R6", 64'({cfg_ld, clksrc}), 64'({m_cfg, m_src}));
            chk("div_trig_en", "R7", 64'({dld, trig, clk_en}), 64'({m_dld, m_trig, m_en}));
            chk("xbar", "R8", 64'(xbar), 64'(m_xbar));
            chk("rst_groups", "R9", 64'({bus, periph, l2}), 64'({m_bus, m_per, m_l2}));
        end
    end

    task automatic req(input int id);
        @(negedge clk);
        start = 1'b1;
        cluster = CW'(id);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 4 * D) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);
        chk("reset rst_rel", "R1", 64'(rst_rel), 64'h1);
        chk("reset l2", "R1", 64'(l2), 64'h1);
        chk("reset core iso", "R1", 64'({c_io, c_mem}), 64'hFCFC);
        chk("reset busy", "R1", 64'(busy), 64'h0);

        req(0);
        repeat (3) @(negedge clk);
        chk("cluster 0 already on", "R2", 64'(busy), 64'h0);

        req(4); req(5); req(7);
        repeat (3) @(negedge clk);
        chk("out-of-range busy", "R3", 64'(busy), 64'h0);
        chk("out-of-range rst_rel", "R3", 64'(rst_rel), 64'h1);

        req(1);
        repeat (8) @(negedge clk);
        req(2);
        wait_idle();
        chk("request while busy, cluster 2 untouched", "R11", 64'(rst_rel[2]), 64'h0);
        chk("cluster 1 now on", "R2", 64'(l2), 64'h3);

        req(1);
        repeat (3) @(negedge clk);
        chk("repeat request for cluster 1", "R2", 64'(busy), 64'h0);

        @(negedge clk);
        start = 1'b1;
        cluster = 3'd3;
        repeat (D + 10) @(negedge clk);
        start = 1'b0;
        chk("held request ends once", "R2", 64'(busy), 64'h0);
        chk("cluster 3 on", "R9", 64'(l2), 64'hB);

        req(2);
        wait_idle();
        chk("all clusters on", "R9", 64'({bus, periph, l2}), 64'hFFF);
        chk("all pll isolation dropped", "R5", 64'(oiso), 64'h0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule